// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers many raw interrupt sources and turns them into a small number of request lines toward a processor. Sources are grouped into banks of `SRC_PER_BANK` lines (32 by default), and each bank raises its own request output whenever any of its enabled sources is pending. Software reaches the block through a simple synchronous read/write port. Through that port it picks each source's trigger mode, masks or unmasks the source, forces a source pending by software, and acknowledges a source once it has been handled.

Every raw line passes through a two-flop synchronizer and is then conditioned according to its mode. There are four modes, selected per source by an edge-select bit and a polarity bit. The level modes are level-high (edge 0, polarity 1) and level-low (edge 0, polarity 0). The edge modes are rising (edge 1, polarity 1) and falling (edge 1, polarity 0). A detected edge moves the source into its latched-pending state, where it stays until software writes its acknowledge bit. A level source reports its live conditioned level. A software-forced pending bit stays set until it is acknowledged.

For each bank the block also gives a helper output: the index of the lowest-numbered enabled pending source, and a valid flag. Software uses it to choose which source to service first. A source numbered n sits in bank n/32 at bit n%32.

Top module: `intc_banked`

## Requirements
- R1: Each bank holds six 32-bit words at byte offsets 0x00 status (read-only), 0x04 enable, 0x08 set, 0x0C clear, 0x10 polarity and 0x14 edge-select. The bus uses byte address bits [4:2] within the bank. A read with `rd_en` loads `rdata` at the next clock edge, and `rdata` holds that value until the next read.
- R2: Bank b occupies byte addresses b*24 to b*24+23. A read at or beyond `NUM_BANKS*24` returns zero, and a write there changes nothing.
- R3: In level mode the status bit follows the synchronized input: level-high when polarity=1 and edge=0, level-low when polarity=0 and edge=0. An input change driven before clock edge k shows in status after edge k+1.
- R4: In edge mode (edge=1), polarity=1 detects rising edges and polarity=0 detects falling edges. An edge driven before clock edge k sets the pending bit after edge k+2, and the bit stays set until it is cleared.
- R5: `irq_o[b]` is high exactly when (status AND enable) of bank b is nonzero.
- R6: `idx_o` for bank b (bits b*5 to b*5+4) gives the lowest set bit of status AND enable, and `idx_vld_o[b]` flags that result as nonzero. When nothing is pending, the index is 0.
- R7: After reset every enable is 0, every polarity bit is 1, every edge bit is 0 except bank 0 bits 13, 14 and 15 (edge=1, rising), nothing is pending, all request lines are low and `rdata` is 0.
- R8: Writing 1 to a bit of the clear word drops that source's latched pending state, and writing 0 has no effect. An edge detected in the same cycle as a clear write leaves the bit pending.
- R9: Writing 1 to a bit of the set word makes that source pending (in any mode) until it is cleared. The set and clear words always read as zero.
- R10: For a level source whose level is active, a clear write leaves its status bit at 1.
- R11: Writes to the status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | SRC_PER_BANK | Write data |
| rdata | output | SRC_PER_BANK | Read data, registered |
| src_i | input | NUM_BANKS*SRC_PER_BANK | Raw source lines, bank b at bits b*32 and up |
| irq_o | output | NUM_BANKS | Per-bank request lines |
| idx_o | output | NUM_BANKS*IDX_W | Per-bank lowest enabled pending index |
| idx_vld_o | output | NUM_BANKS | Per-bank index valid flags |

## Verification
The assertions rely on three assumptions about the inputs: reset is held high from the first clock edge, every bus strobe and address is settled before the edge that samples it, and the raw source lines may change at any time because the synchronizer absorbs them. The stimulus drives every input on the falling clock edge. It holds reset for several cycles at the start, and it toggles source bits freely, sometimes in the same cycle as a clear, set or mode write. Bus addresses land on every word of every bank, and some land past the last bank, so the out-of-range and read-as-zero properties are exercised as well as the normal ones.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // byte distance between consecutive banks
    localparam int unsigned BANK_STRIDE = 24;

    // per-source trigger mode, encoded as {edge_sel, polarity}
    typedef enum logic [1:0] {
        TRIG_LVL_LO    = 2'b00,
        TRIG_LVL_HI    = 2'b01,
        TRIG_EDGE_FALL = 2'b10,
        TRIG_EDGE_RISE = 2'b11
    } trig_e;

    // word slot inside one bank (byte offset / 4)
    typedef enum logic [2:0] {
        RG_STATUS = 3'd0,
        RG_ENABLE = 3'd1,
        RG_SET    = 3'd2,
        RG_CLEAR  = 3'd3,
        RG_POL    = 3'd4,
        RG_EDGE   = 3'd5
    } reg_e;

endpackage

// File: rtl/intc_sync.sv
// Two-flop synchronizer followed by one history flop used for edge detection.
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/intc_trig.sv
// Per-source trigger conditioning: one mode decode per bit.
module intc_trig
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] edge_i,
    output logic [W-1:0] lvl_hit_o,
    output logic [W-1:0] edge_hit_o
);
    for (genvar i = 0; i < W; i++) begin : g_src
        trig_e mode;
        logic  lvl_hit;
        logic  edge_hit;

        assign mode = trig_e'({edge_i[i], pol_i[i]});

        always_comb begin
            lvl_hit  = 1'b0;
            edge_hit = 1'b0;
            unique case (mode)
                TRIG_LVL_HI:    lvl_hit  = cur_i[i];
                TRIG_LVL_LO:    lvl_hit  = ~cur_i[i];
                TRIG_EDGE_RISE: edge_hit = cur_i[i] & ~prev_i[i];
                TRIG_EDGE_FALL: edge_hit = ~cur_i[i] & prev_i[i];
                default:        lvl_hit  = 1'b0;
            endcase
        end

        assign lvl_hit_o[i]  = lvl_hit;
        assign edge_hit_o[i] = edge_hit;
    end
endmodule

// File: rtl/intc_bank.sv
// One bank: address decode, configuration words, pending state, read contribution.
module intc_bank
    import intc_pkg::*;
#(
    parameter int          BANK_IDX = 0,
    parameter int          W        = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [W-1:0] EDGE_RST = '0,
    parameter logic [W-1:0] POL_RST  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      lvl_hit_i,
    input  logic [W-1:0]      edge_hit_i,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      edge_o,
    output logic [W-1:0]      status_o,
    output logic [W-1:0]      enable_o,
    output logic [W-1:0]      rd_data_o,
    output logic              irq_o
);
    localparam int unsigned BASE   = BANK_IDX * BANK_STRIDE;
    localparam int unsigned LIMIT  = BASE + BANK_STRIDE;
    localparam int          XW     = ADDR_W + 1;

    logic [XW-1:0] addr_x;
    logic [XW-1:0] off;
    logic          hit;
    reg_e          sel;

    assign addr_x = {1'b0, addr_i};
    assign hit    = (addr_x >= XW'(BASE)) && (addr_x < XW'(LIMIT));
    assign off    = addr_x - XW'(BASE);
    assign sel    = reg_e'(3'(off >> 2));

    logic [W-1:0] en_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] edge_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;

    // write-one masks for the set and clear words
    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (wr_en_i && hit) begin
            if (sel == RG_SET)   set_m = wdata_i;
            if (sel == RG_CLEAR) clr_m = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= POL_RST;
            edge_q <= EDGE_RST;
            pend_q <= '0;
        end else begin
            // a fresh edge outranks an acknowledge in the same cycle
            pend_q <= (pend_q & ~clr_m) | set_m | edge_hit_i;
            if (wr_en_i && hit) begin
                unique case (sel)
                    RG_ENABLE: en_q   <= wdata_i;
                    RG_POL:    pol_q  <= wdata_i;
                    RG_EDGE:   edge_q <= wdata_i;
                    default:   en_q   <= en_q;
                endcase
            end
        end
    end

    // level sources add their live level; edge sources see no level term
    assign status_o = pend_q | lvl_hit_i;
    assign enable_o = en_q;
    assign pol_o    = pol_q;
    assign edge_o   = edge_q;
    assign irq_o    = |(status_o & en_q);

    always_comb begin
        rd_data_o = '0;
        if (hit) begin
            unique case (sel)
                RG_STATUS: rd_data_o = status_o;
                RG_ENABLE: rd_data_o = en_q;
                RG_POL:    rd_data_o = pol_q;
                RG_EDGE:   rd_data_o = edge_q;
                default:   rd_data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_lowest.sv
// Lowest-set-bit finder for one bank's masked requests.
module intc_lowest #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);
    always_comb begin
        idx_o = '0;
        vld_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
                vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_banked.sv
module intc_banked
    import intc_pkg::*;
#(
    parameter int                    NUM_BANKS       = 5,
    parameter int                    SRC_PER_BANK    = 32,
    parameter int                    ADDR_W          = 8,
    parameter logic [SRC_PER_BANK-1:0] BANK0_EDGE_RST = 32'h0000_E000,
    parameter int                    IDX_W           = $clog2(SRC_PER_BANK)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [SRC_PER_BANK-1:0]           wdata,
    output logic [SRC_PER_BANK-1:0]           rdata,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0] src_i,
    output logic [NUM_BANKS-1:0]              irq_o,
    output logic [NUM_BANKS*IDX_W-1:0]        idx_o,
    output logic [NUM_BANKS-1:0]              idx_vld_o
);
    localparam int W  = SRC_PER_BANK;
    localparam int NW = NUM_BANKS * W;

    logic [NW-1:0] cur_w;
    logic [NW-1:0] prev_w;
    logic [NW-1:0] pol_w;
    logic [NW-1:0] edge_w;
    logic [NW-1:0] lvl_w;
    logic [NW-1:0] det_w;
    logic [NW-1:0] sts_w;
    logic [NW-1:0] en_w;
    logic [NW-1:0] rd_w;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [W-1:0] EDGE_INIT = (b == 0) ? BANK0_EDGE_RST : '0;

        intc_sync #(.W(W)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (src_i[b*W +: W]),
            .cur_o  (cur_w[b*W +: W]),
            .prev_o (prev_w[b*W +: W])
        );

        intc_trig #(.W(W)) u_trig (
            .cur_i      (cur_w[b*W +: W]),
            .prev_i     (prev_w[b*W +: W]),
            .pol_i      (pol_w[b*W +: W]),
            .edge_i     (edge_w[b*W +: W]),
            .lvl_hit_o  (lvl_w[b*W +: W]),
            .edge_hit_o (det_w[b*W +: W])
        );

        intc_bank #(
            .BANK_IDX (b),
            .W        (W),
            .ADDR_W   (ADDR_W),
            .EDGE_RST (EDGE_INIT),
            .POL_RST  ({W{1'b1}})
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr_en_i    (wr_en),
            .addr_i     (addr),
            .wdata_i    (wdata),
            .lvl_hit_i  (lvl_w[b*W +: W]),
            .edge_hit_i (det_w[b*W +: W]),
            .pol_o      (pol_w[b*W +: W]),
            .edge_o     (edge_w[b*W +: W]),
            .status_o   (sts_w[b*W +: W]),
            .enable_o   (en_w[b*W +: W]),
            .rd_data_o  (rd_w[b*W +: W]),
            .irq_o      (irq_o[b])
        );

        intc_lowest #(.W(W), .IDX_W(IDX_W)) u_low (
            .req_i (sts_w[b*W +: W] & en_w[b*W +: W]),
            .idx_o (idx_o[b*IDX_W +: IDX_W]),
            .vld_o (idx_vld_o[b])
        );
    end

    // at most one bank decodes a given address, so OR-ing is a mux
    logic [W-1:0] rd_any;
    always_comb begin
        rd_any = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            rd_any = rd_any | rd_w[b*W +: W];
        end
    end

    logic [W-1:0] rdata_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_any;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/intc_banked_chk.sv
module intc_banked_chk
    import intc_pkg::*;
#(
    parameter int NB = 5,
    parameter int W  = 32,
    parameter int AW = 8,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  rdata,
    input logic [NB-1:0] irq_o,
    input logic [NB-1:0] idx_vld_o,
    input logic [NB*IW-1:0] idx_o,
    input logic [NB*W-1:0]  sts_w,
    input logic [NB*W-1:0]  en_w
);
    // R5
    irq_vld_agree_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == idx_vld_o);

    // R7
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == '0 && rdata == '0));

    // R2
    oob_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(addr) >= NB * BANK_STRIDE) |=> (rdata == '0));

    // R9
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && int'(addr) < NB * BANK_STRIDE &&
         ((int'(addr) % BANK_STRIDE) inside {8, 9, 10, 11, 12, 13, 14, 15}))
        |=> (rdata == '0));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        logic [W-1:0]  req;
        logic [IW-1:0] ix;
        assign req = sts_w[b*W +: W] & en_w[b*W +: W];
        assign ix  = idx_o[b*IW +: IW];

        // R6
        lowest_idx_chk: assert property (@(posedge clk) disable iff (rst)
            idx_vld_o[b] |-> (req[ix] && ((req & ((W'(1) << ix) - W'(1))) == '0)));

        // R9
        set_forces_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && int'(addr) == b * BANK_STRIDE + 8)
            |=> ((sts_w[b*W +: W] & $past(wdata)) == $past(wdata)));
    end
endmodule

bind intc_banked intc_banked_chk #(
    .NB (NUM_BANKS),
    .W  (SRC_PER_BANK),
    .AW (ADDR_W),
    .IW (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_o     (irq_o),
    .idx_vld_o (idx_vld_o),
    .idx_o     (idx_o),
    .sts_w     (sts_w),
    .en_w      (en_w)
);

// File: tb/tb_intc_banked.sv
`timescale 1ns/1ps
module tb_intc_banked;
    localparam int NB  = 5;
    localparam int W   = 32;
    localparam int AW  = 8;
    localparam int IW  = 5;
    localparam int STR = 24;

    logic            clk   = 1'b0;
    logic            rst   = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr  = '0;
    logic [W-1:0]    wdata = '0;
    logic [W-1:0]    rdata;
    logic [NB*W-1:0] src   = '0;
    logic [NB-1:0]   irq;
    logic [NB-1:0]   vld;
    logic [NB*IW-1:0] idx;

    intc_banked #(
        .NUM_BANKS(NB), .SRC_PER_BANK(W), .ADDR_W(AW)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .src_i(src), .irq_o(irq),
        .idx_o(idx), .idx_vld_o(vld)
    );

    always #2 clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string ph    = "R7";

    // ---------------- behavioural reference ----------------
    logic [W-1:0] m_en[NB], m_pol[NB], m_edg[NB], m_pend[NB];
    logic [W-1:0] m_p1[NB], m_p2[NB], m_p3[NB];
    logic [W-1:0] t_pend[NB];
    logic [W-1:0] m_rd;
    int           wa, wb, ww;

    function automatic logic [W-1:0] m_stat(int b);
        logic [W-1:0] s;
        bit active;
        for (int i = 0; i < W; i++) begin
            active = m_pol[b][i] ? m_p2[b][i] : !m_p2[b][i];
            s[i]   = m_pend[b][i] || (!m_edg[b][i] && active);
        end
        return s;
    endfunction

    function automatic logic [W-1:0] m_read(int a);
        int b, w;
        if (a >= NB * STR) return '0;
        b = a / STR;
        w = (a % STR) / 4;
        case (w)
            0: return m_stat(b);
            1: return m_en[b];
            4: return m_pol[b];
            5: return m_edg[b];
            default: return '0;
        endcase
    endfunction

    function automatic int m_low(int b);
        logic [W-1:0] r;
        r = m_stat(b) & m_en[b];
        for (int i = 0; i < W; i++) if (r[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_en[b] = '0; m_pol[b] = '1;
                m_edg[b] = (b == 0) ? 32'h0000_E000 : '0;
                m_pend[b] = '0; m_p1[b] = '0; m_p2[b] = '0; m_p3[b] = '0;
            end
            m_rd = '0;
        end else begin
            wa = int'(addr);
            if (rd_en) m_rd = m_read(wa);
            for (int b = 0; b < NB; b++) t_pend[b] = m_pend[b];
            wb = wa / STR;
            ww = (wa % STR) / 4;
            if (wr_en && wa < NB * STR) begin
                if (ww == 2) t_pend[wb] = t_pend[wb] | wdata;
                if (ww == 3) t_pend[wb] = t_pend[wb] & ~wdata;
            end
            for (int b = 0; b < NB; b++)
                for (int i = 0; i < W; i++)
                    if (m_edg[b][i]) begin
                        if (m_pol[b][i] && m_p2[b][i] && !m_p3[b][i]) t_pend[b][i] = 1'b1;
                        if (!m_pol[b][i] && !m_p2[b][i] && m_p3[b][i]) t_pend[b][i] = 1'b1;
                    end
            if (wr_en && wa < NB * STR) begin
                if (ww == 1) m_en[wb]  = wdata;
                if (ww == 4) m_pol[wb] = wdata;
                if (ww == 5) m_edg[wb] = wdata;
            end
            for (int b = 0; b < NB; b++) begin
                m_pend[b] = t_pend[b];
                m_p3[b] = m_p2[b];
                m_p2[b] = m_p1[b];
                m_p1[b] = src[b*W +: W];
            end
        end
    end

    // ---------------- comparison ----------------
    task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({ph, " rdata"}, rdata, m_rd);
            for (int b = 0; b < NB; b++) begin
                int lo;
                lo = m_low(b);
                chk($sformatf("R5 irq bank%0d", b), W'(irq[b]),
                    W'((m_stat(b) & m_en[b]) != '0));
                chk($sformatf("R6 vld bank%0d", b), W'(vld[b]), W'(lo >= 0));
                chk($sformatf("R6 idx bank%0d", b), W'(idx[b*IW +: IW]),
                    W'((lo >= 0) ? lo : 0));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(bit we, bit re, int a, logic [W-1:0] d);
        wr_en = we; rd_en = re; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask
    task automatic wr(int a, logic [W-1:0] d); cyc(1, 0, a, d); endtask
    task automatic rd(int a);                  cyc(0, 1, a, '0); endtask
    task automatic idle(int n);                repeat (n) cyc(0, 0, 0, '0); endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        ph = "R7";  // reset defaults
        rd(20); rd(2*STR + 16); rd(STR + 4); rd(0); idle(2);

        ph = "R1";  // register map and read-back
        wr(STR + 4, 32'h0000_0F0F); rd(STR + 4);
        wr(3*STR + 16, 32'h1234_5678); rd(3*STR + 16);
        wr(4*STR + 20, 32'h8000_0001); rd(4*STR + 20);
        wr(4*STR + 20, '0); wr(3*STR + 16, '1); rd(3*STR + 16);

        ph = "R2";  // bank stride and out-of-range
        rd(120); wr(124, '1); rd(124); rd(255);
        wr(2*STR + 4, 32'h0000_00FF); rd(2*STR + 4); rd(4);

        ph = "R11"; // status writes ignored
        wr(0, '1); rd(0); wr(STR, '1); rd(STR);

        ph = "R3";  // level-high and level-low
        wr(STR + 4, '1);
        src[W +: W] = 32'h0000_0101; idle(1); rd(STR); idle(2); rd(STR);
        wr(STR + 16, 32'hFFFF_FFEF); rd(STR); idle(2); rd(STR);
        src[W + 4] = 1'b1; idle(3); rd(STR);
        src[W +: W] = 32'h0000_0001; idle(3); rd(STR);

        ph = "R4";  // rising on bank 0 defaults, falling on bank 2
        wr(4, '1);
        src[13] = 1'b1; idle(1); src[13] = 1'b0; idle(4); rd(0);
        src[14] = 1'b1; idle(5); rd(0);
        wr(2*STR + 20, 32'h0000_0003); wr(2*STR + 16, 32'hFFFF_FFFC);
        src[2*W +: 2] = 2'b11; idle(4); rd(2*STR);
        src[2*W +: 2] = 2'b00; idle(4); rd(2*STR);

        ph = "R8";  // acknowledge, write-zero, edge versus clear
        wr(12, 32'h0000_2000); rd(0); wr(12, '0); rd(0);
        wr(2*STR + 12, 32'h0000_0001); rd(2*STR);
        for (int k = 0; k < 4; k++) begin
            src[15] = 1'b0; wr(12, 32'h0000_8000); idle(3);
            src[15] = 1'b1; idle(k); wr(12, 32'h0000_8000); rd(0); idle(3);
        end

        ph = "R9";  // software set, set/clear read as zero
        wr(3*STR + 4, '1); wr(3*STR + 8, 32'hA5A5_0000); rd(3*STR);
        rd(3*STR + 8); rd(3*STR + 12); wr(3*STR + 12, '1); rd(3*STR);
        wr(STR + 8, 32'h0000_0002); rd(STR);

        ph = "R10"; // clear on an active level source
        wr(STR + 12, 32'h0000_0003); rd(STR); idle(1); rd(STR);

        ph = "R6";  // lowest index walk
        wr(4*STR + 4, '1); wr(4*STR + 8, 32'h8421_0000);
        for (int k = 0; k < 4; k++) begin
            idle(1); wr(4*STR + 12, 32'h0000_0001 << (16 + 5*k)); rd(4*STR);
        end

        ph = "R8 mix"; // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            int op, b;
            for (int j = 0; j < NB; j++)
                src[j*W +: W] = src[j*W +: W] ^ ($urandom() & $urandom() & $urandom());
            op = $urandom_range(0, 9);
            b  = $urandom_range(0, NB - 1);
            if (op < 4)
                wr(b*STR + 4*$urandom_range(0, 5), $urandom() & $urandom());
            else if (op < 7)
                rd(b*STR + 4*$urandom_range(0, 5));
            else if (op == 7)
                rd($urandom_range(NB*STR, 255));
            else
                idle(1);
        end

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule